// File: doc/BRIEF.md
# Event Timer with Steerable Prescaler

This block is an 8-bit up-counting timer for a small microcontroller core. It counts either instruction cycles (a one-clock enable pulse from the core) or edges on an external pin. A choice of rising or falling edge applies to the pin. One binary prescaler sits next to the counter. It can be steered to slow the counter down, or it can be handed to the watchdog timebase path and divide the raw watchdog pulses. The counter then counts every selected event undivided.

Software sees the count value, a sticky overflow flag and an interrupt request. The request is gated by a local enable and a global enable. A write to the counter loads a new value and restarts the prescaler from zero, so the next divided step always takes a full period. The watchdog timeout, reset generation and the oscillators are not part of this block: the watchdog timebase arrives as a one-clock pulse input, and the divided result leaves as a one-clock tick.

Top module: `tmr_shared_prescale`

## Requirements
- R1: With `src_ext`=0 the counter source is `cyc_en`, and pin activity is ignored. With `src_ext`=1 the source is edges on `ext_pin`, and `cyc_en` is ignored. With no source event and no write, `count_q` holds its value.
- R2: With `edge_fall`=0 only low-to-high transitions of `ext_pin` are counted. With `edge_fall`=1 only high-to-low transitions are counted.
- R3: `ext_pin` passes through a two-flop synchronizer before edge detection. Each transition yields exactly one source event, and two events never fall on consecutive clocks.
- R4: With `ps_to_wdt`=0 the counter advances once per 2^(rate+1) source events, for `rate` 0..7, which gives 2 up to 256.
- R5: With `ps_to_wdt`=1, `wdt_tick` pulses once per 2^rate `wdt_base` pulses, which gives 1 up to 128. The counter then advances on every source event.
- R6: An increment from 0xFF wraps `count_q` to 0x00 and sets `ovf_flag`.
- R7: When `wr_en` is high, `count_q` takes `wr_data` on the next clock and the prescaler count returns to zero. A write takes priority over an increment in the same cycle.
- R8: `ovf_flag` stays set until a cycle with `flag_clr` high. An overflow in that same cycle wins over the clear.
- R9: `irq` is high only while `ovf_flag`, `irq_en` and `gie` are all high.
- R10: With `ps_to_wdt`=0, every `wdt_base` pulse appears on `wdt_tick` one clock later, undivided.
- R11: After reset, `count_q`=0, `ovf_flag`=0, `irq`=0 and `wdt_tick`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_en | input | 1 | Instruction-cycle pulse (internal source) |
| ext_pin | input | 1 | Asynchronous external count pin |
| wdt_base | input | 1 | Raw watchdog timebase pulse |
| src_ext | input | 1 | 1: count pin edges, 0: count instruction cycles |
| edge_fall | input | 1 | 1: falling pin edges, 0: rising pin edges |
| ps_to_wdt | input | 1 | 1: prescaler on watchdog path, 0: on counter |
| rate | input | 3 | Prescaler rate code |
| wr_en | input | 1 | Counter write strobe |
| wr_data | input | 8 | Counter write value |
| flag_clr | input | 1 | Clear overflow flag |
| irq_en | input | 1 | Local interrupt enable |
| gie | input | 1 | Global interrupt enable |
| count_q | output | 8 | Counter value |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Gated interrupt request |
| wdt_tick | output | 1 | Divided watchdog tick pulse |

## Verification
The prescaler's internal phase is the hardest state to observe from the ports, because it only shows when a divided step reaches the counter. The stimulus clears the phase with a counter write. It then applies a partial period, writes again, and applies exactly one step fewer than a full period. An uncleared prescaler would then show one extra increment. The rate sweeps run 520 events per code, so the undivided and lightly divided settings cross 0xFF. This drives the overflow flag from the rate path itself.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  typedef enum logic {PS_ON_COUNTER = 1'b0, PS_ON_WDOG = 1'b1} ps_owner_e;
  typedef enum logic {EDGE_RISE = 1'b0, EDGE_FALL = 1'b1} edge_sel_e;
endpackage

// File: rtl/tmr_pin_edge.sv
`timescale 1ns/1ps
module tmr_pin_edge
  import tmr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pin,
  input  edge_sel_e edge_sel,
  output logic      evt
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= pin;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  always_comb begin
    if (edge_sel == EDGE_FALL) evt = prev_q & ~sync_q;
    else                       evt = sync_q & ~prev_q;
  end

  AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> !evt); // R3
endmodule

// File: rtl/tmr_prescaler.sv
`timescale 1ns/1ps
module tmr_prescaler #(
  parameter int PS_W  = 8,
  parameter int SH_W  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            evt,
  input  logic [SH_W-1:0] shift,
  output logic            pulse
);
  logic [PS_W-1:0] ps_q, ps_d, mask;

  always_comb begin
    mask  = ~({PS_W{1'b1}} << shift);
    pulse = evt & ~clr & ((ps_q & mask) == mask);
    if (clr)      ps_d = '0;
    else if (evt) ps_d = ps_q + 1'b1;
    else          ps_d = ps_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ps_q <= '0;
    else        ps_q <= ps_d;
  end

  AST_PS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (ps_q == '0)); // R7
  AST_PS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !evt) |=> $stable(ps_q)); // R4
endmodule

// File: rtl/tmr_count8.sv
`timescale 1ns/1ps
module tmr_count8 #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         flag_clr,
  output logic [W-1:0] count,
  output logic         ovf_flag
);
  localparam logic [W-1:0] TOP = {W{1'b1}};
  logic [W-1:0] cnt_d;
  logic         flag_d, wrap;

  always_comb begin
    wrap = inc & ~wr_en & (count == TOP);
    if (wr_en)    cnt_d = wr_data;
    else if (inc) cnt_d = count + 1'b1;
    else          cnt_d = count;
    if (wrap)          flag_d = 1'b1;
    else if (flag_clr) flag_d = 1'b0;
    else               flag_d = ovf_flag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count    <= '0;
      ovf_flag <= 1'b0;
    end else begin
      count    <= cnt_d;
      ovf_flag <= flag_d;
    end
  end

  AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (count == $past(wr_data))); // R7
  AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !wr_en && count == TOP) |=> (ovf_flag && count == '0)); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !flag_clr) |=> ovf_flag); // R8
endmodule

// File: rtl/tmr_shared_prescale.sv
`timescale 1ns/1ps
module tmr_shared_prescale
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int RATE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_en,
  input  logic              ext_pin,
  input  logic              wdt_base,
  input  logic              src_ext,
  input  logic              edge_fall,
  input  logic              ps_to_wdt,
  input  logic [RATE_W-1:0] rate,
  input  logic              wr_en,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              flag_clr,
  input  logic              irq_en,
  input  logic              gie,
  output logic [CNT_W-1:0]  count_q,
  output logic              ovf_flag,
  output logic              irq,
  output logic              wdt_tick
);
  localparam int PS_W = 2 ** RATE_W;
  localparam int SH_W = RATE_W + 1;

  logic rst_meta, rst_core;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_core <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_core <= rst_meta;
    end
  end

  ps_owner_e owner;
  edge_sel_e edge_sel;
  logic pin_evt, src_evt, ps_evt, ps_pulse, cnt_inc, tick_d;
  logic [SH_W-1:0] shift;

  always_comb begin
    owner    = ps_owner_e'(ps_to_wdt);
    edge_sel = edge_sel_e'(edge_fall);
    src_evt  = src_ext ? pin_evt : cyc_en;
    if (owner == PS_ON_WDOG) begin
      shift   = {1'b0, rate};
      ps_evt  = wdt_base;
      cnt_inc = src_evt;
      tick_d  = ps_pulse;
    end else begin
      shift   = {1'b0, rate} + 1'b1;
      ps_evt  = src_evt;
      cnt_inc = ps_pulse;
      tick_d  = wdt_base;
    end
    irq = ovf_flag & irq_en & gie;
  end

  tmr_pin_edge u_edge (
    .clk(clk), .rst_n(rst_core), .pin(ext_pin), .edge_sel(edge_sel), .evt(pin_evt)
  );

  tmr_prescaler #(.PS_W(PS_W), .SH_W(SH_W)) u_ps (
    .clk(clk), .rst_n(rst_core), .clr(wr_en), .evt(ps_evt), .shift(shift), .pulse(ps_pulse)
  );

  tmr_count8 #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_core), .inc(cnt_inc), .wr_en(wr_en), .wr_data(wr_data),
    .flag_clr(flag_clr), .count(count_q), .ovf_flag(ovf_flag)
  );

  always_ff @(posedge clk or negedge rst_core) begin
    if (!rst_core) wdt_tick <= 1'b0;
    else           wdt_tick <= tick_d;
  end

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_core)
    (!src_ext && !cyc_en && !wr_en) |=> $stable(count_q)); // R1
  AST_TICK_PASS: assert property (@(posedge clk) disable iff (!rst_core)
    (!ps_to_wdt && wdt_base) |=> wdt_tick); // R10
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_core)
    irq |-> (ovf_flag && gie && irq_en)); // R9
endmodule

// File: tb/tb_tmr_shared_prescale.sv
`timescale 1ns/1ps
module tb_tmr_shared_prescale;
  logic clk = 1'b0;
  logic rst_n, cyc_en, ext_pin, wdt_base, src_ext, edge_fall, ps_to_wdt;
  logic [2:0] rate;
  logic wr_en, flag_clr, irq_en, gie;
  logic [7:0] wr_data, count_q;
  logic ovf_flag, irq, wdt_tick;
  int checks = 0, errors = 0, ticks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tmr_shared_prescale dut (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .ext_pin(ext_pin), .wdt_base(wdt_base),
    .src_ext(src_ext), .edge_fall(edge_fall), .ps_to_wdt(ps_to_wdt), .rate(rate),
    .wr_en(wr_en), .wr_data(wr_data), .flag_clr(flag_clr), .irq_en(irq_en), .gie(gie),
    .count_q(count_q), .ovf_flag(ovf_flag), .irq(irq), .wdt_tick(wdt_tick)
  );

  always @(negedge clk) if (rst_n && wdt_tick) ticks++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic write_cnt(input logic [7:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_data = v; flag_clr = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; flag_clr = 1'b0;
    ticks = 0;
  endtask

  task automatic events(input int n, input bit with_wdt);
    for (int i = 0; i < n; i++) begin
      cyc_en = 1'b1; wdt_base = with_wdt;
      @(negedge clk);
    end
    cyc_en = 1'b0; wdt_base = 1'b0;
    idle(3);
  endtask

  task automatic pin_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      ext_pin = 1'b1; idle(3);
      ext_pin = 1'b0; idle(3);
    end
    idle(4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cyc_en = 0; ext_pin = 0; wdt_base = 0; src_ext = 0; edge_fall = 0;
    ps_to_wdt = 0; rate = 0; wr_en = 0; wr_data = 0; flag_clr = 0; irq_en = 0; gie = 0;
    idle(4);
    rst_n = 1'b1;
    idle(4);
    // R11 reset state
    chk("R11 count", count_q, 0);
    chk("R11 ovf", ovf_flag, 0);
    chk("R11 irq", irq, 0);
    chk("R11 tick", wdt_tick, 0);

    // R4 and R10: prescaler on counter, all rate codes, 520 events
    for (int r = 0; r < 8; r++) begin
      ps_to_wdt = 0; rate = 3'(r);
      write_cnt(8'h00);
      events(520, 1'b1);
      chk($sformatf("R4 count rate%0d", r), count_q, (520 >> (r + 1)) & 255);
      chk($sformatf("R6 ovf rate%0d", r), ovf_flag, int'((520 >> (r + 1)) > 255));
      chk($sformatf("R10 ticks rate%0d", r), ticks, 520);
    end

    // R5: prescaler on watchdog path
    for (int r = 0; r < 8; r++) begin
      ps_to_wdt = 1; rate = 3'(r);
      write_cnt(8'h00);
      events(520, 1'b1);
      chk($sformatf("R5 count rate%0d", r), count_q, 520 & 255);
      chk($sformatf("R6 ovf undivided rate%0d", r), ovf_flag, 1);
      chk($sformatf("R5 ticks rate%0d", r), ticks, 520 >> r);
    end

    // R7: write clears prescaler phase (rate 2 on counter = divide by 8)
    ps_to_wdt = 0; rate = 3'd2;
    write_cnt(8'h00);
    events(5, 1'b0);
    write_cnt(8'h10);
    chk("R7 load", count_q, 16);
    events(7, 1'b0);
    chk("R7 prescaler cleared", count_q, 16);
    events(1, 1'b0);
    chk("R7 full period", count_q, 17);

    // R1, R2, R3: external pin with undivided counter; cyc_en running and ignored
    src_ext = 1; ps_to_wdt = 1; rate = 0;
    for (int e = 0; e < 2; e++) begin
      edge_fall = e[0];
      write_cnt(8'h00);
      cyc_en = 1'b1;
      ext_pin = 1'b1; idle(6);
      chk($sformatf("R2 after rise fall=%0d", e), count_q, (e == 0) ? 1 : 0);
      ext_pin = 1'b0; idle(6);
      chk($sformatf("R2 after fall fall=%0d", e), count_q, 1);
      cyc_en = 1'b0;
    end
    edge_fall = 0;
    write_cnt(8'h00);
    pin_pulses(9);
    chk("R3 one count per edge", count_q, 9);
    ps_to_wdt = 0; rate = 0;
    write_cnt(8'h00);
    pin_pulses(10);
    chk("R4 pin divided by 2", count_q, 5);

    // R1: internal source ignores pin
    src_ext = 0; ps_to_wdt = 1;
    write_cnt(8'h20);
    pin_pulses(4);
    chk("R1 pin ignored", count_q, 32);
    events(3, 1'b0);
    chk("R1 cyc counted", count_q, 35);

    // R6, R8, R9: overflow, sticky flag, interrupt gating
    write_cnt(8'hFF);
    chk("R8 write clears flag", ovf_flag, 0);
    events(1, 1'b0);
    chk("R6 wrap", count_q, 0);
    chk("R6 flag", ovf_flag, 1);
    for (int m = 0; m < 4; m++) begin
      @(negedge clk); irq_en = m[0]; gie = m[1]; #1;
      chk($sformatf("R9 irq en=%0d gie=%0d", m[0], m[1]), irq, int'(m == 3));
    end
    events(10, 1'b0);
    chk("R8 sticky", ovf_flag, 1);
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0; #1;
    chk("R8 cleared", ovf_flag, 0);
    chk("R9 irq drops", irq, 0);

    // R8: overflow and clear in the same cycle, overflow wins
    write_cnt(8'hFF);
    @(negedge clk); cyc_en = 1'b1; flag_clr = 1'b1;
    @(negedge clk); cyc_en = 1'b0; flag_clr = 1'b0;
    chk("R8 set beats clear", ovf_flag, 1);

    // R7: write beats increment in the same cycle
    @(negedge clk); cyc_en = 1'b1; wr_en = 1'b1; wr_data = 8'h40;
    @(negedge clk); cyc_en = 1'b0; wr_en = 1'b0;
    chk("R7 write priority", count_q, 64);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule